// File: doc/BRIEF.md
# Four-Channel Servo Pulse Generator

This block produces up to four servo control pulse trains from a single shared time base. A prescaler turns the system clock into a fixed tick, normally one microsecond long. A period counter walks through the ticks of one frame and wraps at a programmable length. Each channel compares the counter against its own threshold, so every output rises at the start of a frame and falls once its width has elapsed.

Software sets the frame rate in hertz, a width per channel in ticks, a channel enable mask and an arm bit, all through a simple write port, and reads settings back through a separate read address. The block turns the rate into a frame length with a small iterative divider. Widths and frame length are held in staging registers. They reach the live counter only at a frame wrap, or when arming forces a restart. Disarming takes effect at the end of the current frame, so no pulse is ever cut short.

Writes use one address map. Addresses 0 to 7 select a channel width by index. Address 8 holds the rate, address 9 the arm bit (bit 0), and address 10 the enable mask. The tick is CLK_HZ / TICK_HZ clock cycles long.

Top module: `servo_pwm`

## Requirements
- R1: The counter advances one tick every CLK_HZ/TICK_HZ clock cycles. A frame lasts floor(TICK_HZ/rate) ticks. After reset the rate is DEFAULT_RATE.
- R2: An enabled, running output is high from the first tick of a frame for (W-1) ticks, where W is the last width written (no high time for W of 0 or 1). It is high for the whole frame when W-1 is at least the frame length.
- R3: Writing width W to address i (0 to 3) stores W-1, or 0 when W is 0. Reading address i returns the stored value plus one.
- R4: A width or rate change does not alter the live frame. It takes effect at the next frame wrap or at an arm write.
- R5: A rate write below MIN_RATE or above MAX_RATE is rejected, and so is a rate write made while the previous rate is still being converted (CNT_W cycles after it was accepted). A rejected write raises cfgErr for one cycle, one cycle after the write, and changes nothing. An accepted rate reads back at address 8 and reaches staging CNT_W cycles after the write.
- R6: Writing 1 to bit 0 of address 9 copies all staged values into the live registers, restarts the frame at tick zero and runs the counter. The outputs show the new frame from the next cycle.
- R7: Writing 0 to bit 0 of address 9 while running lets the current frame finish in full, then stops the counter. Address 9 reads 1 only while running and not winding down.
- R8: While not armed, the counter is stopped and every output is low.
- R9: Bit i of the enable mask (address 10) gates output i at once. The mask resets to INIT_MASK and reads back at address 10.
- R10: A write to a width index of 4 to 7, or to an address above 10, changes no state and raises cfgErr one cycle later.
- R11: After reset the block is idle, all outputs and cfgErr are low, and every width reads DEFAULT_WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | CNT_W | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | CNT_W | Read data for rdAddr |
| cfgErr | output | 1 | One-cycle pulse after a rejected write |
| pwmOut | output | NCH | Servo pulse outputs |

## Verification
Widths of 0, 1, a mid value and one beyond the frame are used together, which separates the W-1 offset, the zero case and the saturated case. Rates at, just below and just above the legal range, plus a second rate written during conversion, tell range rejection apart from busy rejection. Width and rate writes made in mid-frame show whether staging holds until the wrap. A disarm issued just after a rising edge shows whether the last pulse runs to full length. A rate change made while idle, followed by an arm, shows that the forced restart loads staged values without waiting for a wrap.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_RATE = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_ARM  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} armState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic forceUpd;  // restart frame, copy staged values to live
    logic cntEn;     // counter runs, outputs allowed
  } pwmStrobe_t;
endpackage

// File: rtl/servo_pwm_ctrl.sv
module servo_pwm_ctrl
  import servo_pwm_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int CNT_W         = 20,
  parameter int RATE_W        = 10,
  parameter int TICK_HZ       = 1_000_000,
  parameter int DEFAULT_RATE  = 50,
  parameter int MIN_RATE      = 50,
  parameter int MAX_RATE      = 400,
  parameter int DEFAULT_WIDTH = 1500,
  parameter logic [NCH-1:0] INIT_MASK = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [CNT_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [CNT_W-1:0]          rdData,
  input  logic                      periodEnd,
  output pwmStrobe_t                strb,
  output logic [NCH-1:0][CNT_W-1:0] cmpPre,
  output logic [CNT_W-1:0]          arrPre,
  output logic [NCH-1:0]            chanMask,
  output logic                      cfgErr
);
  localparam int STEP_W = $clog2(CNT_W + 1);
  localparam logic [CNT_W-1:0] DIVIDEND = CNT_W'(TICK_HZ);
  localparam logic [CNT_W-1:0] DEF_ARR  = CNT_W'(TICK_HZ / DEFAULT_RATE - 1);
  localparam logic [CNT_W-1:0] DEF_CMP  = CNT_W'(DEFAULT_WIDTH - 1);

  armState_t state;
  logic [RATE_W-1:0] rateReg;

  // write decode
  logic chanSel, chanValid, rateSel, armSel, maskSel, rateInRange, rateAccept, badWr;
  logic divBusy;

  assign chanSel     = wrEn && !wrAddr[3];
  assign chanValid   = {1'b0, wrAddr[2:0]} < 4'(NCH);
  assign rateSel     = wrEn && (wrAddr == ADDR_RATE);
  assign armSel      = wrEn && (wrAddr == ADDR_ARM);
  assign maskSel     = wrEn && (wrAddr == ADDR_MASK);
  assign rateInRange = (wrData >= CNT_W'(MIN_RATE)) && (wrData <= CNT_W'(MAX_RATE));
  assign rateAccept  = rateSel && rateInRange && !divBusy;
  assign badWr       = (chanSel && !chanValid) || (rateSel && !rateAccept)
                     || (wrEn && wrAddr[3] && (wrAddr > ADDR_MASK));

  // staged compare values, one per channel
  for (genvar i = 0; i < NCH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cmpPre[i] <= DEF_CMP;
      else if (chanSel && chanValid && (wrAddr[2:0] == 3'(i)))
        cmpPre[i] <= (wrData == '0) ? '0 : wrData - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanMask <= INIT_MASK;
      rateReg  <= RATE_W'(DEFAULT_RATE);
      cfgErr   <= 1'b0;
    end else begin
      cfgErr <= badWr;
      if (maskSel)    chanMask <= wrData[NCH-1:0];
      if (rateAccept) rateReg  <= wrData[RATE_W-1:0];
    end
  end

  // arm sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      state <= ST_IDLE;
    else if (armSel && wrData[0])
      state <= ST_RUN;
    else if (armSel && (state == ST_RUN))
      state <= ST_DRAIN;
    else if ((state == ST_DRAIN) && periodEnd)
      state <= ST_IDLE;
  end

  assign strb.forceUpd = armSel && wrData[0];
  assign strb.cntEn    = (state != ST_IDLE);

  // iterative restoring divider: frame ticks = TICK_HZ / rate
  logic [RATE_W-1:0] remR, denR;
  logic [CNT_W-1:0]  quoR;
  logic [STEP_W-1:0] stepCnt;
  logic [RATE_W:0]   remShift, remDiff;
  logic              geq;
  logic [RATE_W-1:0] remNext;
  logic [CNT_W-1:0]  quoNext;

  always_comb begin
    remShift = {remR, quoR[CNT_W-1]};
    geq      = remShift >= {1'b0, denR};
    remDiff  = remShift - {1'b0, denR};
    remNext  = geq ? remDiff[RATE_W-1:0] : remShift[RATE_W-1:0];
    quoNext  = {quoR[CNT_W-2:0], geq};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divBusy <= 1'b0;
      stepCnt <= '0;
      remR    <= '0;
      quoR    <= '0;
      denR    <= '0;
      arrPre  <= DEF_ARR;
    end else if (rateAccept) begin
      divBusy <= 1'b1;
      stepCnt <= STEP_W'(CNT_W);
      remR    <= '0;
      quoR    <= DIVIDEND;
      denR    <= wrData[RATE_W-1:0];
    end else if (divBusy) begin
      remR    <= remNext;
      quoR    <= quoNext;
      stepCnt <= stepCnt - 1'b1;
      if (stepCnt == STEP_W'(1)) begin
        divBusy <= 1'b0;
        arrPre  <= quoNext - 1'b1;
      end
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (!rdAddr[3]) begin
      for (int i = 0; i < NCH; i++)
        if (rdAddr[2:0] == 3'(i)) rdData = cmpPre[i] + 1'b1;
    end else begin
      case (rdAddr)
        ADDR_RATE: rdData = CNT_W'(rateReg);
        ADDR_ARM:  rdData = CNT_W'(state == ST_RUN);
        ADDR_MASK: rdData = CNT_W'(chanMask);
        default:   rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/servo_pwm_dp.sv
module servo_pwm_dp
  import servo_pwm_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int CNT_W         = 20,
  parameter int PRESC         = 2,
  parameter int TICK_HZ       = 1_000_000,
  parameter int DEFAULT_RATE  = 50,
  parameter int DEFAULT_WIDTH = 1500
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pwmStrobe_t                strb,
  input  logic [NCH-1:0][CNT_W-1:0] cmpPre,
  input  logic [CNT_W-1:0]          arrPre,
  input  logic [NCH-1:0]            chanMask,
  output logic                      periodEnd,
  output logic [NCH-1:0]            pwmOut
);
  localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESC - 1);
  localparam logic [CNT_W-1:0] DEF_ARR  = CNT_W'(TICK_HZ / DEFAULT_RATE - 1);
  localparam logic [CNT_W-1:0] DEF_CMP  = CNT_W'(DEFAULT_WIDTH - 1);

  logic [PRE_W-1:0]          preCnt;
  logic [CNT_W-1:0]          tickCnt, arrAct;
  logic [NCH-1:0][CNT_W-1:0] cmpAct;
  logic                      tick, loadLive;

  assign tick      = (preCnt == PRE_LAST);
  assign periodEnd = strb.cntEn && tick && (tickCnt == arrAct);
  assign loadLive  = strb.forceUpd || periodEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strb.forceUpd || periodEnd) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strb.cntEn) begin
      if (tick) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrAct <= DEF_ARR;
      for (int i = 0; i < NCH; i++) cmpAct[i] <= DEF_CMP;
    end else if (loadLive) begin
      arrAct <= arrPre;
      cmpAct <= cmpPre;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign pwmOut[i] = strb.cntEn && chanMask[i] && (tickCnt < cmpAct[i]);
  end
endmodule

// File: rtl/servo_pwm.sv
module servo_pwm
  import servo_pwm_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int CNT_W         = 20,
  parameter int RATE_W        = 10,
  parameter int CLK_HZ        = 2_000_000,
  parameter int TICK_HZ       = 1_000_000,
  parameter int DEFAULT_RATE  = 50,
  parameter int MIN_RATE      = 50,
  parameter int MAX_RATE      = 400,
  parameter int DEFAULT_WIDTH = 1500,
  parameter logic [NCH-1:0] INIT_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [3:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              cfgErr,
  output logic [NCH-1:0]    pwmOut
);
  localparam int PRESC = CLK_HZ / TICK_HZ;

  pwmStrobe_t                strb;
  logic [NCH-1:0][CNT_W-1:0] cmpPre;
  logic [CNT_W-1:0]          arrPre;
  logic [NCH-1:0]            chanMask;
  logic                      periodEnd;

  servo_pwm_ctrl #(
    .NCH(NCH), .CNT_W(CNT_W), .RATE_W(RATE_W), .TICK_HZ(TICK_HZ),
    .DEFAULT_RATE(DEFAULT_RATE), .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE),
    .DEFAULT_WIDTH(DEFAULT_WIDTH), .INIT_MASK(INIT_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .periodEnd(periodEnd), .strb(strb),
    .cmpPre(cmpPre), .arrPre(arrPre), .chanMask(chanMask), .cfgErr(cfgErr)
  );

  servo_pwm_dp #(
    .NCH(NCH), .CNT_W(CNT_W), .PRESC(PRESC), .TICK_HZ(TICK_HZ),
    .DEFAULT_RATE(DEFAULT_RATE), .DEFAULT_WIDTH(DEFAULT_WIDTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpPre(cmpPre), .arrPre(arrPre),
    .chanMask(chanMask), .periodEnd(periodEnd), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/servo_pwm_chk.sv
module servo_pwm_chk
  import servo_pwm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CNT_W    = 20,
  parameter int MIN_RATE = 50,
  parameter int MAX_RATE = 400
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [3:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic             cfgErr,
  input pwmStrobe_t       strb,
  input logic             periodEnd
);
  a_r5_rate_range_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_RATE &&
     (wrData < CNT_W'(MIN_RATE) || wrData > CNT_W'(MAX_RATE))) |=> cfgErr);

  a_r10_bad_index_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr[3] && ({1'b0, wrAddr[2:0]} >= 4'(NCH))) |=> cfgErr);

  a_r11_err_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(wrEn));

  a_r6_arm_runs: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceUpd |=> strb.cntEn);

  a_r7_stop_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.cntEn) |-> $past(periodEnd));
endmodule

bind servo_pwm servo_pwm_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .MIN_RATE(MIN_RATE), .MAX_RATE(MAX_RATE)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .cfgErr(cfgErr), .strb(strb), .periodEnd(periodEnd)
);

// File: tb/servo_pwm_bench.sv
module servo_pwm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CNT_W = 20;
  localparam int CLK_HZ = 20_000;
  localparam int TICK_HZ = 10_000;
  localparam int P = CLK_HZ / TICK_HZ;
  localparam int DEF_W = 15;
  localparam logic [3:0] INIT_M = 4'b1011;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [CNT_W-1:0] wrData = '0, rdData;
  logic cfgErr;
  logic [NCH-1:0] pwmOut;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_pwm #(
    .NCH(NCH), .CNT_W(CNT_W), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ),
    .DEFAULT_WIDTH(DEF_W), .INIT_MASK(INIT_M)
  ) u_servo_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cfgErr(cfgErr), .pwmOut(pwmOut)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: clocks elapsed in frame, frame length in ticks
  int phase, perAct, perPre, pend, newPer, rateM, stM;
  int cmpPreM[NCH], cmpActM[NCH];
  logic [NCH-1:0] maskM;
  bit errM, busyM;

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; perAct = TICK_HZ/50; perPre = TICK_HZ/50; pend = 0; newPer = 0;
      rateM = 50; stM = 0; maskM = INIT_M; errM = 0;
      for (int i = 0; i < NCH; i++) begin cmpPreM[i] = DEF_W-1; cmpActM[i] = DEF_W-1; end
    end else begin
      busyM = pend > 0;
      errM = 0;
      if (wrEn && wrAddr == 9 && wrData[0]) begin
        phase = 0; cmpActM = cmpPreM; perAct = perPre; stM = 1;
      end else begin
        if (stM != 0) begin
          if (phase == perAct*P - 1) begin
            phase = 0; cmpActM = cmpPreM; perAct = perPre;
            if (stM == 2) stM = 0;
          end else phase++;
        end
        if (wrEn && wrAddr == 9 && stM == 1) stM = 2;
      end
      if (pend > 0) begin pend--; if (pend == 0) perPre = newPer; end
      if (wrEn) begin
        if (wrAddr < 8) begin
          if (wrAddr < NCH) cmpPreM[wrAddr] = (wrData == 0) ? 0 : int'(wrData) - 1;
          else errM = 1;
        end else if (wrAddr == 8) begin
          if (wrData < 50 || wrData > 400 || busyM) errM = 1;
          else begin rateM = int'(wrData); newPer = TICK_HZ / int'(wrData); pend = CNT_W; end
        end else if (wrAddr == 10) maskM = wrData[NCH-1:0];
        else if (wrAddr > 10) errM = 1;
      end
    end
  end

  // per-clock comparison against the reference (R2, R8, R9, R5)
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [NCH-1:0] expOut;
      for (int i = 0; i < NCH; i++)
        expOut[i] = (stM != 0) && maskM[i] && ((phase / P) < cmpActM[i]);
      check(pwmOut === expOut, "R2", "pwmOut per clock", int'(pwmOut), int'(expOut));
      check(cfgErr === errM, "R5", "cfgErr per clock", int'(cfgErr), int'(errM));
    end
  end

  task automatic wr(int a, int d);
    wrEn = 1; wrAddr = 4'(a); wrData = CNT_W'(d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    rdAddr = 4'(a);
    #1;
    check(rdData === CNT_W'(exp), tag, $sformatf("read addr %0d", a), int'(rdData), exp);
  endtask

  task automatic measure(int ch, int expHi, int expPer, bit doChk, string tag);
    int hi = 0, per = 0;
    while (pwmOut[ch] !== 1'b0) @(negedge clk);
    while (pwmOut[ch] !== 1'b1) @(negedge clk);
    while (pwmOut[ch] === 1'b1) begin hi++; per++; @(negedge clk); end
    while (pwmOut[ch] === 1'b0) begin per++; @(negedge clk); end
    if (doChk) begin
      check(hi == expHi, tag, $sformatf("high clocks ch%0d", ch), hi, expHi);
      check(per == expPer, tag, $sformatf("frame clocks ch%0d", ch), per, expPer);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(pwmOut === '0, "R11", "outputs after reset", int'(pwmOut), 0);
    check(cfgErr === 1'b0, "R11", "cfgErr after reset", int'(cfgErr), 0);
    rd(0, DEF_W, "R11");
    rd(3, DEF_W, "R11");
    rd(10, int'(INIT_M), "R9");
    rd(8, 50, "R1");
    // R3 widths with offset, including zero and beyond-frame values
    wr(0, 11); wr(1, 0); wr(2, 1); wr(3, 250);
    rd(0, 11, "R3");
    rd(1, 1, "R3");
    rd(2, 1, "R3");
    // R8 idle stays low
    repeat (50) @(negedge clk);
    check(pwmOut === '0, "R8", "idle outputs", int'(pwmOut), 0);
    rd(9, 0, "R8");
    // R6 arm, R1/R2 frame at default rate
    wr(9, 1);
    rd(9, 1, "R6");
    measure(0, 10*P, 200*P, 1, "R1");
    check(pwmOut[3] === 1'b1, "R2", "saturated width ch3", int'(pwmOut[3]), 1);
    check(pwmOut[2] === 1'b0, "R9", "masked ch2", int'(pwmOut[2]), 0);
    // R4 mid-frame width change waits for the wrap
    repeat (30) @(negedge clk);
    wr(0, 41);
    measure(0, 40*P, 200*P, 1, "R4");
    // R5 rate handling
    wr(0, 21);
    wr(8, 49);
    check(cfgErr === 1'b1, "R5", "rate below range", int'(cfgErr), 1);
    wr(8, 401);
    check(cfgErr === 1'b1, "R5", "rate above range", int'(cfgErr), 1);
    rd(8, 50, "R5");
    wr(8, 400);
    check(cfgErr === 1'b0, "R5", "legal rate accepted", int'(cfgErr), 0);
    wr(8, 100);
    check(cfgErr === 1'b1, "R5", "rate while converting", int'(cfgErr), 1);
    rd(8, 400, "R5");
    measure(0, 0, 0, 0, "R5");
    measure(0, 20*P, 25*P, 1, "R5");
    // R10 bad index and unmapped address
    wr(5, 7);
    check(cfgErr === 1'b1, "R10", "index 5 write", int'(cfgErr), 1);
    wr(12, 3);
    check(cfgErr === 1'b1, "R10", "unmapped write", int'(cfgErr), 1);
    rd(0, 21, "R10");
    rd(10, int'(INIT_M), "R10");
    // R9 mask change
    wr(10, 5);
    rd(10, 5, "R9");
    @(negedge clk);
    check(pwmOut[3] === 1'b0, "R9", "ch3 masked off", int'(pwmOut[3]), 0);
    // R7 disarm right after a rising edge: pulse runs to full length
    measure(0, 20*P, 25*P, 1, "R2");
    wr(9, 0);
    rd(9, 0, "R7");
    begin
      int hi = 0;
      while (pwmOut[0] === 1'b1) begin hi++; @(negedge clk); end
      check(hi == 20*P - 1, "R7", "last pulse length", hi, 20*P - 1);
    end
    repeat (60) @(negedge clk);
    check(pwmOut === '0, "R7", "stopped after frame", int'(pwmOut), 0);
    // R6 rate staged while idle, loaded by arming
    wr(8, 100);
    repeat (CNT_W + 5) @(negedge clk);
    check(pwmOut === '0, "R8", "idle after rate write", int'(pwmOut), 0);
    wr(9, 1);
    check(pwmOut[0] === 1'b1, "R6", "high right after arm", int'(pwmOut[0]), 1);
    measure(0, 20*P, 100*P, 1, "R6");
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule